// File: doc/BRIEF.md
# Expander Interrupt Aggregator with Acknowledge

This block gathers eight interrupt causes inside an I/O expander and turns them into a single request line toward the host. Seven of the causes arrive as one-cycle event pulses. Each pulse sets a sticky pending flag, and that flag stays set until the host acknowledges it. The eighth cause, at position 0, is a summary of the GPIO logic: it is the live OR of three banked per-pin pending bytes supplied by the GPIO edge detectors. It is not stored here, and only the GPIO logic can clear it.

The host reaches the block through a byte-wide register bus. A write completes in the clock cycle in which `reg_wr` is high, and read data is combinational from `reg_addr`. The bus has no handshake and never applies back-pressure, so every access is accepted immediately.

The block has four host-visible registers:
- A source-enable mask.
- A read-only pending view.
- A write-one-to-clear acknowledge strobe.
- A pin-configuration register that picks the request polarity and chooses between push-pull and open-drain drive.

The pad-facing outputs `irq_pin_out` and `irq_pin_oe` are registered.

Top module: `exp_irq_hub`

## Requirements
- R1: After reset the enable register (0x42), the latched pending bits and the pin configuration (0x41) read 0, `irq_pin_oe` is 0 and `irq_pin_out` is 1.
- R2: An event pulse on source n (1..7) sets pending bit n, read at address 0x08. The bit stays set, whether or not source n is enabled, until it is acknowledged.
- R3: Writing address 0x44 clears every pending bit n (1..7) whose data bit n is 1. Bits written 0 are left unchanged.
- R4: If an event and an acknowledge for the same bit fall in the same cycle, the bit stays set.
- R5: Pending bit 0 equals the OR of the three GPIO pending bytes, which read back at 0x0C, 0x0D and 0x0E (bank 0 is the low byte of `gpio_pend`). Acknowledge bit 0 has no effect on it.
- R6: The enable register at 0x42 is read/write. The request is active exactly when (pending AND enable) is nonzero, so an enable of 0 keeps the request inactive.
- R7: Pin configuration bit 1 is the polarity. The active level of `irq_pin_out` equals bit 1 (0 active low, 1 active high), and the inactive level is its inverse.
- R8: Pin configuration bit 0 is the drive mode. With 1 (push-pull), `irq_pin_oe` is always 1. With 0 (open-drain), `irq_pin_oe` is 1 only while the request is active.
- R9: The pin outputs follow the pending, enable and configuration state one clock later.
- R10: Writes to 0x08 change nothing, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| src_evt | input | 7 | Event pulses for sources 7..1 (bit index = source number) |
| gpio_pend | input | 24 | Three GPIO pending bytes, bank 0 in bits 7:0 |
| irq_pin_out | output | 1 | Request line level |
| irq_pin_oe | output | 1 | Request line output enable |

## Verification
Two operations can land on the same pending bit in the same cycle: a new event and the host's acknowledge of that bit. The bench provokes this by raising a source pulse together with an acknowledge write for that source in one cycle. It then reads the pending register and expects the bit to still be set. A second coincidence targets the GPIO summary bit. An acknowledge of bit 0 is written while a bank byte is nonzero, and the summary bit must survive.

// File: rtl/exp_irq_pkg.sv
package exp_irq_pkg;
  localparam logic [7:0] ADR_PEND   = 8'h08;
  localparam logic [7:0] ADR_GBANK0 = 8'h0C;
  localparam logic [7:0] ADR_PINCFG = 8'h41;
  localparam logic [7:0] ADR_SRCEN  = 8'h42;
  localparam logic [7:0] ADR_ACK    = 8'h44;

  // bit 1: polarity (1 = active high), bit 0: drive (1 = push-pull)
  typedef struct packed {
    logic act_high;
    logic push_pull;
  } pin_cfg_t;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import exp_irq_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned NSRC   = 8,
  parameter int unsigned GBANKS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic [NSRC-1:0]      pend_vec,
  input  logic [GBANKS*DW-1:0] gpio_pend,
  output logic [NSRC-1:0]      src_en,
  output pin_cfg_t             pin_cfg,
  output logic [NSRC-1:0]      ack_mask
);
  localparam int unsigned CFGW = $bits(pin_cfg_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en  <= '0;
      pin_cfg <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADR_SRCEN)  src_en  <= reg_wdata[NSRC-1:0];
      if (reg_addr == ADR_PINCFG) pin_cfg <= pin_cfg_t'(reg_wdata[CFGW-1:0]);
    end
  end

  // acknowledge is a strobe, bit 0 (GPIO summary) is never acknowledged here
  always_comb begin
    ack_mask = '0;
    if (reg_wr && reg_addr == ADR_ACK)
      ack_mask = {reg_wdata[NSRC-1:1], 1'b0};
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADR_PEND)   reg_rdata[NSRC-1:0] = pend_vec;
    if (reg_addr == ADR_SRCEN)  reg_rdata[NSRC-1:0] = src_en;
    if (reg_addr == ADR_PINCFG) reg_rdata[CFGW-1:0] = pin_cfg;
    for (int b = 0; b < GBANKS; b++) begin
      if (reg_addr == ADR_GBANK0 + 8'(b))
        reg_rdata = gpio_pend[b*DW +: DW];
    end
  end

  // R10: read-only pending view is never a storage target
  a_r10_pend_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_PEND) |=> ($stable(src_en) && $stable(pin_cfg)));
endmodule

// File: rtl/irq_latch.sv
module irq_latch #(
  parameter int unsigned DW     = 8,
  parameter int unsigned NSRC   = 8,
  parameter int unsigned GBANKS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:1]      src_evt,
  input  logic [NSRC-1:0]      ack_mask,
  input  logic [GBANKS*DW-1:0] gpio_pend,
  output logic [NSRC-1:0]      pend_vec
);
  // GPIO summary is live, owned by the GPIO logic
  assign pend_vec[0] = |gpio_pend;

  for (genvar i = 1; i < NSRC; i++) begin : g_src
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (src_evt[i]) flag_q <= 1'b1;   // event wins over acknowledge
      else if (ack_mask[i]) flag_q <= 1'b0;
    end
    assign pend_vec[i] = flag_q;

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !ack_mask[i]) |=> flag_q);
    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      src_evt[i] |=> flag_q);
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_mask[i] && !src_evt[i]) |=> !flag_q);
  end
endmodule

// File: rtl/irq_pin.sv
module irq_pin
  import exp_irq_pkg::*;
#(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_vec,
  input  logic [NSRC-1:0] src_en,
  input  pin_cfg_t        pin_cfg,
  output logic            irq_pin_out,
  output logic            irq_pin_oe
);
  logic active;
  assign active = |(pend_vec & src_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pin_out <= 1'b1;
      irq_pin_oe  <= 1'b0;
    end else begin
      irq_pin_out <= active ? pin_cfg.act_high : ~pin_cfg.act_high;
      irq_pin_oe  <= pin_cfg.push_pull | active;
    end
  end

  a_r8_pp_drives: assert property (@(posedge clk) disable iff (!rst_n)
    pin_cfg.push_pull |=> irq_pin_oe);
  a_r8_od_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_cfg.push_pull && !active) |=> !irq_pin_oe);
  a_r7_active_level: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (irq_pin_out == $past(pin_cfg.act_high)));
  a_r6_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en == '0) |=> (irq_pin_out != $past(pin_cfg.act_high)));
endmodule

// File: rtl/exp_irq_hub.sv
module exp_irq_hub
  import exp_irq_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned NSRC   = 8,
  parameter int unsigned GBANKS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic [NSRC-1:1]      src_evt,
  input  logic [GBANKS*DW-1:0] gpio_pend,
  output logic                 irq_pin_out,
  output logic                 irq_pin_oe
);
  logic [NSRC-1:0] pend_vec;
  logic [NSRC-1:0] src_en;
  logic [NSRC-1:0] ack_mask;
  pin_cfg_t        pin_cfg;

  irq_regs #(.DW(DW), .NSRC(NSRC), .GBANKS(GBANKS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pend_vec(pend_vec),
    .gpio_pend(gpio_pend), .src_en(src_en), .pin_cfg(pin_cfg),
    .ack_mask(ack_mask)
  );

  irq_latch #(.DW(DW), .NSRC(NSRC), .GBANKS(GBANKS)) u_latch (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .ack_mask(ack_mask),
    .gpio_pend(gpio_pend), .pend_vec(pend_vec)
  );

  irq_pin #(.NSRC(NSRC)) u_pin (
    .clk(clk), .rst_n(rst_n), .pend_vec(pend_vec), .src_en(src_en),
    .pin_cfg(pin_cfg), .irq_pin_out(irq_pin_out), .irq_pin_oe(irq_pin_oe)
  );

  // R5: GPIO summary is not affected by an acknowledge of bit 0
  a_r5_gpio_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mask[0] == 1'b0));
endmodule

// File: tb/exp_irq_hub_tb.sv
module exp_irq_hub_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [7:1]  src_evt = '0;
  logic [23:0] gpio_pend = '0;
  logic        irq_pin_out;
  logic        irq_pin_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  exp_irq_hub dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_evt(src_evt),
    .gpio_pend(gpio_pend), .irq_pin_out(irq_pin_out), .irq_pin_oe(irq_pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(logic [7:1] m);
    src_evt = m;
    tick();
    src_evt = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h42, d); chk("R1 enable reset", d, 8'h00);
    rd(8'h41, d); chk("R1 pincfg reset", d, 8'h00);
    rd(8'h08, d); chk("R1 pending reset", d, 8'h00);
    chk("R1 oe reset", {7'd0, irq_pin_oe}, 8'h00);
    chk("R1 out reset", {7'd0, irq_pin_out}, 8'h01);
  endtask

  task automatic t_latch();
    logic [7:0] d;
    pulse(7'b0000100);               // source 3
    rd(8'h08, d); chk("R2 latched while disabled", d, 8'h08);
    repeat (4) tick();
    rd(8'h08, d); chk("R2 held", d, 8'h08);
    chk("R6 disabled oe", {7'd0, irq_pin_oe}, 8'h00);
    chk("R6 disabled out", {7'd0, irq_pin_out}, 8'h01);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    pulse(7'b0010000);               // source 5
    rd(8'h08, d); chk("R2 two sources", d, 8'h28);
    wr(8'h44, 8'h08);
    rd(8'h08, d); chk("R3 selective ack", d, 8'h20);
    wr(8'h44, 8'hDF);
    rd(8'h08, d); chk("R3 zero bits untouched", d, 8'h20);
    wr(8'h44, 8'h20);
    rd(8'h08, d); chk("R3 ack last", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    pulse(7'b0000010);               // source 2
    src_evt = 7'b0000010;
    reg_addr = 8'h44; reg_wdata = 8'h04; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; src_evt = '0;
    rd(8'h08, d); chk("R4 event beats ack", d, 8'h04);
    wr(8'h44, 8'h04);
    rd(8'h08, d); chk("R4 later ack clears", d, 8'h00);
  endtask

  task automatic t_gpio();
    logic [7:0] d;
    gpio_pend = 24'h001000;          // bank 1 = 0x10
    rd(8'h08, d); chk("R5 summary set", d, 8'h01);
    rd(8'h0D, d); chk("R5 bank1 readback", d, 8'h10);
    rd(8'h0C, d); chk("R5 bank0 readback", d, 8'h00);
    wr(8'h44, 8'h01);
    rd(8'h08, d); chk("R5 ack bit0 ignored", d, 8'h01);
    gpio_pend = 24'h800000;
    rd(8'h0E, d); chk("R5 bank2 readback", d, 8'h80);
    gpio_pend = '0;
    rd(8'h08, d); chk("R5 summary clear", d, 8'h00);
  endtask

  task automatic t_pin_od();
    logic [7:0] d;
    wr(8'h42, 8'h02);
    rd(8'h42, d); chk("R6 enable readback", d, 8'h02);
    pulse(7'b0000001);               // source 1
    chk("R9 pin lags one cycle", {7'd0, irq_pin_oe}, 8'h00);
    tick();
    chk("R8 od drives when active", {7'd0, irq_pin_oe}, 8'h01);
    chk("R7 active low", {7'd0, irq_pin_out}, 8'h00);
  endtask

  task automatic t_pin_pp();
    logic [7:0] d;
    wr(8'h41, 8'h03);
    rd(8'h41, d); chk("R7 pincfg readback", d, 8'h03);
    tick();
    chk("R7 active high", {7'd0, irq_pin_out}, 8'h01);
    chk("R8 pp oe", {7'd0, irq_pin_oe}, 8'h01);
    wr(8'h42, 8'h00);
    tick();
    chk("R6 enable zero silences", {7'd0, irq_pin_out}, 8'h00);
    chk("R8 pp drives inactive", {7'd0, irq_pin_oe}, 8'h01);
    wr(8'h41, 8'h00);
    tick();
    chk("R8 od releases inactive", {7'd0, irq_pin_oe}, 8'h00);
    chk("R7 low-active idle high", {7'd0, irq_pin_out}, 8'h01);
  endtask

  task automatic t_readonly();
    logic [7:0] d;
    wr(8'h08, 8'hFF);
    rd(8'h08, d); chk("R10 pending read-only", d, 8'h02);
    rd(8'h42, d); chk("R10 enable untouched", d, 8'h00);
    wr(8'h55, 8'hFF);
    rd(8'h55, d); chk("R10 unmapped reads zero", d, 8'h00);
    rd(8'h42, d); chk("R10 unmapped write no effect", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_latch();
    t_ack();
    t_collide();
    t_gpio();
    t_pin_od();
    t_pin_pp();
    t_readonly();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule